// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block is a 32-bit counter whose count source is chosen at run time. In clock mode it advances on the internal clock, divided down by a programmable prescaler. In the three encoder modes it decodes a two-channel incremental encoder. Those modes count the transitions of channel A alone, of channel B alone, or of both channels, and the level of the other channel sets the direction. The counter wraps between zero and a programmable ceiling. Every wrap raises a one-cycle update pulse and sets a sticky flag.

Software reaches the block through a small synchronous register bus: a write strobe, an address and write data, with read data returned combinationally from the address. Writes to the prescale register go to a holding register. The value in use is loaded only when an update event happens. An update event is either a wrap or a forced update command. This lets software change the division ratio without a glitch. Changes to the ceiling act at once. A count write whose value lies above the ceiling is dropped.

Register map (word addresses):
- 0 control: bit 0 run, bits 2:1 mode, read-only bit 8 direction.
- 1 count.
- 2 ceiling.
- 3 prescale.
- 4 event: write bit 0 forces an update, write bit 1 clears the flag, read bit 0 is the flag.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the ceiling is all ones, the prescale holding value is 0, run is 0, mode is 0, the direction bit (control bit 8) is 0, the flag (event bit 0) is 0 and `upd_evt` is low.
- R2: In mode 0 (clock mode) with run set, the count rises by one every prescale+1 clock cycles. Encoder inputs have no effect in this mode.
- R3: A prescale write has no effect until the next update event. Writing 1 to event bit 0 forces an update: it loads the held prescale value, restarts the prescale divider, sets the flag and pulses `upd_evt`. Writing 1 to event bit 1 clears the flag.
- R4: In mode 1 the count steps on each edge of channel A, up when the new A level differs from B and down when it equals B. Changes on B alone are ignored.
- R5: In mode 2 the count steps on each edge of channel B, up when the new B level equals A and down when it differs. Changes on A alone are ignored.
- R6: In mode 3 every single-channel transition steps the count. The sequence (A,B) = 00, 10, 11, 01, 00 counts up by 4, and the reverse sequence counts down by 4.
- R7: A transition in which both channels change in the same sampled cycle does not step the count.
- R8: The direction bit holds 1 after a down step and 0 after an up step.
- R9: An up step from a count at or above the ceiling gives 0, sets the flag and pulses `upd_evt` for one cycle.
- R10: A down step from 0 gives the ceiling value, sets the flag and pulses `upd_evt`.
- R11: A ceiling write applies to the very next step, with no buffering.
- R12: A count write above the ceiling leaves the count unchanged. A write equal to the ceiling is accepted.
- R13: With run clear the count holds in every mode.
- R14: Encoder inputs pass through a two-stage synchronizer plus a history stage, so the count changes on the third rising clock edge after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr` |
| upd_evt | output | 1 | One-cycle update event pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 16-bit prescaler and two synchronizer stages. Because the ceiling is programmable, small values such as 5 and 100 are enough to cover both wrap directions within a few steps. A prescale of 255 holds the clock-mode count still long enough to show that encoder activity is ignored. Prescale values of 0 and 3, switched with and without a forced update, expose whether the held prescale value is loaded at the right moment.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_INC = 2'd0,
    MODE_QA  = 2'd1,
    MODE_QB  = 2'd2,
    MODE_QX4 = 2'd3
  } qmode_e;

  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_CEIL = 2;
  localparam int A_PSC  = 3;
  localparam int A_EVT  = 4;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_DIR_BIT = 8;
  localparam int EVT_FORCE_BIT = 0;
  localparam int EVT_CLR_BIT   = 1;

  // Direction of an edge on channel A, given the new A level and the B level.
  function automatic logic a_edge_down(input logic a_new, input logic b_lvl);
    return ~(a_new ^ b_lvl);
  endfunction

  // Direction of an edge on channel B, given the A level and the new B level.
  function automatic logic b_edge_down(input logic a_lvl, input logic b_new);
    return a_lvl ^ b_new;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   a_in,
  input  logic   b_in,
  input  qmode_e mode,
  output logic   step,
  output logic   down,
  output logic   dual_chg
);
  logic a_q, b_q;
  logic a_chg, b_chg, only_a, only_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign a_chg    = a_in ^ a_q;
  assign b_chg    = b_in ^ b_q;
  assign only_a   = a_chg & ~b_chg;
  assign only_b   = b_chg & ~a_chg;
  assign dual_chg = a_chg & b_chg;

  always_comb begin
    step = 1'b0;
    down = 1'b0;
    unique case (mode)
      MODE_QA: begin
        step = only_a;
        down = a_edge_down(a_in, b_in);
      end
      MODE_QB: begin
        step = only_b;
        down = b_edge_down(a_in, b_in);
      end
      MODE_QX4: begin
        step = only_a | only_b;
        down = only_a ? a_edge_down(a_in, b_in) : b_edge_down(a_in, b_in);
      end
      default: begin
        step = 1'b0;
        down = 1'b0;
      end
    endcase
  end

  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dual_chg |-> !step); // R7
  AST_INC_NO_QSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INC) |-> !step); // R2
endmodule

// File: rtl/qenc_prescale.sv
module qenc_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             reload,
  input  logic [PSC_W-1:0] psc_hold,
  output logic             tick
);
  logic [PSC_W-1:0] psc_act, div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      div_cnt <= '0;
    end else if (reload) begin
      psc_act <= psc_hold;
      div_cnt <= '0;
    end else if (en) begin
      div_cnt <= (div_cnt == psc_act) ? '0 : div_cnt + 1'b1;
    end
  end

  assign tick = en && (div_cnt == psc_act);

  AST_PSC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= psc_act); // R2
  AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (div_cnt == '0) && (psc_act == $past(psc_hold))); // R3
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ceil,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             wrap
);
  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] lim,
                                                 input logic dn);
    if (dn) return (cur == '0) ? lim : cur - 1'b1;
    else    return (cur >= lim) ? '0 : cur + 1'b1;
  endfunction

  assign wrap = step && !load && (down ? (count == '0) : (count >= ceil));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      dir   <= 1'b0;
    end else if (load) begin
      count <= load_val;
    end else if (step) begin
      count <= next_val(count, ceil, down);
      dir   <= down;
    end
  end

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !down && count >= ceil) |=> (count == '0)); // R9
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && down && count == '0) |=> (count == $past(ceil))); // R10
  AST_DIR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (dir == $past(down))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count)); // R13
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PSC_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              upd_evt
);
  localparam logic [CNT_W-1:0] CEIL_RST = '1;

  logic             run;
  qmode_e           mode;
  logic [CNT_W-1:0] ceil;
  logic [PSC_W-1:0] psc_hold;
  logic             flag;

  logic [1:0]       enc_sync;
  logic             q_step, q_down, q_dual;
  logic             psc_tick, force_upd, reload;
  logic             core_step, core_down, core_wrap, core_dir;
  logic             wr_ctrl, wr_cnt, wr_ceil, wr_psc, wr_evt, cnt_accept, flag_clr;
  logic [CNT_W-1:0] count;

  assign wr_ctrl    = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_cnt     = bus_wr && (bus_addr == ADDR_W'(A_CNT));
  assign wr_ceil    = bus_wr && (bus_addr == ADDR_W'(A_CEIL));
  assign wr_psc     = bus_wr && (bus_addr == ADDR_W'(A_PSC));
  assign wr_evt     = bus_wr && (bus_addr == ADDR_W'(A_EVT));
  assign cnt_accept = wr_cnt && (bus_wdata <= ceil);
  assign force_upd  = wr_evt && bus_wdata[EVT_FORCE_BIT];
  assign flag_clr   = wr_evt && bus_wdata[EVT_CLR_BIT];
  assign reload     = force_upd || core_wrap;

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({enc_a, enc_b}), .dout(enc_sync)
  );

  qenc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .a_in(enc_sync[1]), .b_in(enc_sync[0]),
    .mode(mode), .step(q_step), .down(q_down), .dual_chg(q_dual)
  );

  qenc_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(run && (mode == MODE_INC)),
    .reload(reload), .psc_hold(psc_hold), .tick(psc_tick)
  );

  assign core_step = run && ((mode == MODE_INC) ? psc_tick : q_step);
  assign core_down = (mode != MODE_INC) && q_down;

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(core_step), .down(core_down),
    .load(cnt_accept), .load_val(bus_wdata), .ceil(ceil),
    .count(count), .dir(core_dir), .wrap(core_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      mode     <= MODE_INC;
      ceil     <= CEIL_RST;
      psc_hold <= '0;
      flag     <= 1'b0;
      upd_evt  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run  <= bus_wdata[CTRL_RUN_BIT];
        mode <= qmode_e'(bus_wdata[2:1]);
      end
      if (wr_ceil) ceil <= bus_wdata;
      if (wr_psc)  psc_hold <= bus_wdata[PSC_W-1:0];
      if (reload)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      upd_evt <= reload;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (int'(bus_addr))
      A_CTRL: begin
        bus_rdata[CTRL_RUN_BIT] = run;
        bus_rdata[2:1]          = mode;
        bus_rdata[CTRL_DIR_BIT] = core_dir;
      end
      A_CNT:  bus_rdata = count;
      A_CEIL: bus_rdata = ceil;
      A_PSC:  bus_rdata = CNT_W'(psc_hold);
      A_EVT:  bus_rdata[0] = flag;
      default: bus_rdata = '0;
    endcase
  end

  AST_REJECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && (bus_wdata > ceil) && !core_step) |=> $stable(count)); // R12
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> flag); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_accept) |=> $stable(count)); // R13
  AST_DUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode != MODE_INC && q_dual && !cnt_accept) |=> $stable(count)); // R7
endmodule

// File: tb/tb_qenc_counter.sv
module tb_qenc_counter;
  import qenc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        upd_evt;

  int checks = 0, failures = 0, evt_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  qenc_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .upd_evt(upd_evt)
  );

  always @(negedge clk) if (rst_n && upd_evt) evt_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input bit run, input logic [1:0] m);
    return {29'd0, m, run};
  endfunction

  // Run in clock mode for exactly n active edges (n >= 2), starting from stopped.
  task automatic run_clock(input int n);
    wr(A_CTRL, ctrl_word(1, 2'd0));
    repeat (n - 2) @(negedge clk);
    wr(A_CTRL, ctrl_word(0, 2'd0));
  endtask

  task automatic enc_to(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CEIL, v); chk("R1 ceiling", v, 32'hFFFF_FFFF);
    rd(A_PSC, v);  chk("R1 prescale", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl/dir", v, 0);
    rd(A_EVT, v);  chk("R1 flag", v, 0);
    chk("R1 upd_evt", upd_evt, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(A_PSC, 3);
    wr(A_EVT, 1);
    wr(A_CNT, 0);
    run_clock(40);
    rd(A_CNT, v); chk("R2 count /4 over 40 cycles", v, 10);
    rd(A_CTRL, v); chk("R8 dir up in clock mode", v[8], 0);
  endtask

  task automatic t_psc_reload;
    logic [31:0] v;
    int e0;
    wr(A_EVT, 2);
    wr(A_PSC, 0);
    wr(A_CNT, 0);
    run_clock(20);
    rd(A_CNT, v); chk("R3 held prescale not yet active", v, 5);
    e0 = evt_seen;
    wr(A_EVT, 1);
    rd(A_EVT, v); chk("R3 forced update sets flag", v, 1);
    chk("R3 forced update pulses upd_evt", 32'(evt_seen - e0), 1);
    run_clock(20);
    rd(A_CNT, v); chk("R3 new prescale after forced update", v, 25);
    wr(A_EVT, 2);
    rd(A_EVT, v); chk("R3 flag clear", v, 0);
  endtask

  task automatic t_wrap_up;
    logic [31:0] v;
    int e0;
    wr(A_CEIL, 5);
    wr(A_CNT, 3);
    e0 = evt_seen;
    run_clock(3);
    rd(A_CNT, v); chk("R9 wrap to zero", v, 0);
    rd(A_EVT, v); chk("R9 flag set", v, 1);
    chk("R9 one update pulse", 32'(evt_seen - e0), 1);
    wr(A_EVT, 2);
  endtask

  task automatic t_ceil_now;
    logic [31:0] v;
    wr(A_CEIL, 32'hFFFF_FFFF);
    wr(A_CNT, 10);
    wr(A_CEIL, 4);
    run_clock(2);
    rd(A_CNT, v); chk("R11 lowered ceiling wraps at once", v, 1);
  endtask

  task automatic t_count_write;
    logic [31:0] v;
    wr(A_CEIL, 5);
    wr(A_CNT, 9);
    rd(A_CNT, v); chk("R12 write above ceiling rejected", v, 1);
    wr(A_CNT, 5);
    rd(A_CNT, v); chk("R12 write equal to ceiling accepted", v, 5);
  endtask

  task automatic t_x4;
    logic [31:0] v;
    wr(A_CEIL, 100);
    wr(A_CNT, 50);
    wr(A_CTRL, ctrl_word(1, 2'd3));
    @(negedge clk); enc_a = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = 3'(A_CNT); #1 chk("R14 no change after two edges", bus_rdata, 50);
    @(negedge clk);
    #1 chk("R14 change on third edge", bus_rdata, 51);
    repeat (3) @(negedge clk);
    enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    rd(A_CNT, v); chk("R6 up sequence +4", v, 54);
    rd(A_CTRL, v); chk("R8 dir after up", v[8], 0);
    enc_to(0, 1); enc_to(1, 1); enc_to(1, 0); enc_to(0, 0);
    rd(A_CNT, v); chk("R6 down sequence -4", v, 50);
    rd(A_CTRL, v); chk("R8 dir after down", v[8], 1);
  endtask

  task automatic t_chan_a;
    logic [31:0] v;
    wr(A_CTRL, ctrl_word(1, 2'd1));
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    rd(A_CNT, v); chk("R4 A edges only", v, 52);
    enc_to(0, 1); enc_to(1, 1);
    rd(A_CNT, v); chk("R4 A edge with B equal counts down", v, 51);
    enc_to(0, 1); enc_to(0, 0);
  endtask

  task automatic t_chan_b;
    logic [31:0] v;
    rd(A_CNT, v); chk("R4 restore before B test", v, 52);
    wr(A_CTRL, ctrl_word(1, 2'd2));
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    rd(A_CNT, v); chk("R5 B edges only", v, 54);
    enc_to(0, 1);
    rd(A_CNT, v); chk("R5 B edge with A differing counts down", v, 53);
    enc_to(0, 0);
    rd(A_CNT, v); chk("R5 B falling with A equal counts up", v, 54);
  endtask

  task automatic t_dual;
    logic [31:0] v;
    wr(A_CTRL, ctrl_word(1, 2'd3));
    enc_to(1, 1); enc_to(0, 0);
    rd(A_CNT, v); chk("R7 simultaneous change ignored", v, 54);
  endtask

  task automatic t_underflow;
    logic [31:0] v;
    int e0;
    wr(A_CNT, 0);
    wr(A_EVT, 2);
    e0 = evt_seen;
    enc_to(0, 1);
    rd(A_CNT, v); chk("R10 underflow to ceiling", v, 100);
    rd(A_EVT, v); chk("R10 flag set", v, 1);
    chk("R10 update pulse", 32'(evt_seen - e0), 1);
    enc_to(0, 0);
  endtask

  task automatic t_frozen;
    logic [31:0] v;
    wr(A_CNT, 20);
    wr(A_CTRL, ctrl_word(0, 2'd3));
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    rd(A_CNT, v); chk("R13 run clear holds count", v, 20);
  endtask

  task automatic t_inc_ignores;
    logic [31:0] v;
    wr(A_PSC, 255);
    wr(A_EVT, 3);
    wr(A_CTRL, ctrl_word(1, 2'd0));
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    wr(A_CTRL, ctrl_word(0, 2'd0));
    rd(A_CNT, v); chk("R2 encoder ignored in clock mode", v, 20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_psc_reload;
    t_wrap_up;
    t_ceil_now;
    t_count_write;
    t_x4;
    t_chan_a;
    t_chan_b;
    t_dual;
    t_underflow;
    t_frozen;
    t_inc_ignores;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule